// File: doc/BRIEF.md
# Multichannel Prescaled Pulse-Width Modulator

This block is a bank of pulse-width modulator channels behind a small word-addressed register bus. One shared enable register holds a run bit for each channel. Each channel has two registers. The first is a window register that gives the count at which the active phase begins and the count at which it ends. The second is a timing register that gives the top count of the period, a drive code for each phase, and a 3-bit selector for the clock divider.

Each channel runs a prescaler from the selected division ratio. The prescaler steps a period counter, which climbs from zero to the programmed top and then wraps. The output takes the active-phase level while the counter is inside the window, and the inactive-phase level otherwise. Every register can be written plainly or through three alias addresses that set, clear or toggle only the written bits, so software never needs a read-modify-write sequence. Changes made while a channel runs are held back until its next wrap.

Top module: `pwm_bank`

## Requirements
- R1: The enable register is at address 0x00. Bit n starts channel n. Bits at or above the channel count read as 0. After reset every register reads 0 and every output is low.
- R2: Each register occupies four word addresses. Offset +0x0 writes the whole value, +0x4 ORs in the written bits, +0x8 clears the written bits, and +0xC inverts the written bits.
- R3: A read at any of a register's four addresses returns its current contents. Addresses that map to no register ignore writes and read as 0.
- R4: Channel n's window register is at 0x10+0x20·n and its timing register is at 0x20+0x20·n. Timing-register bits [31:23] always read 0.
- R5: Timing bits [22:20] pick the prescale ratio. Codes 0 through 7 give 1, 2, 4, 8, 16, 64, 256 and 1024 clocks per count step.
- R6: Timing bits [15:0] hold the top count P. The counter runs 0..P and wraps, so one period lasts ratio·(P+1) clocks, up to 65536 steps.
- R7: Window bits [15:0] are the start count S and bits [31:16] the end count E. The phase is active while S ≤ count < E, so the window is empty when S ≥ E and is clipped at P.
- R8: Timing bits [17:16] are the active-phase drive code and bits [19:18] the inactive-phase drive code. Code 3 drives high; every other code drives low.
- R9: While its enable bit is 0, a channel holds its counters at zero and drives the inactive code currently in its timing register. Setting the bit starts the count at 0 on the next clock.
- R10: Window or timing values written while a channel runs take effect only at that channel's next wrap.
- R11: Channels run independently, each from its own registers and enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus and all counters |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Byte address of the bus access, word aligned |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe, one access per cycle |
| rdata | output | 32 | Read data for `addr`, combinational |
| pwm_out | output | NCH | One modulated output per channel |

## Verification
The assertions assume word-aligned addresses, one write per strobed cycle, and a reset applied before the first clock. The bench meets these by driving `addr`, `wdata` and `we` only on falling edges through a single write task, and by holding `rst_n` low across the first edges. The counter-range and restart properties also assume each channel is configured before it is enabled. The stimulus always disables a channel, writes both of its registers, and only then sets the enable bit through the set alias.

// File: rtl/pwm_bank_pkg.sv
`timescale 1ns/1ps
package pwm_bank_pkg;
  localparam int REG_W  = 32;
  localparam int CNT_W  = 16;
  localparam int DIVR_W = 11;
  localparam int PER_W  = 23;
  localparam logic [REG_W-1:0] PER_MASK = 32'h007F_FFFF;

  typedef enum logic [1:0] {OP_WRITE, OP_SET, OP_CLR, OP_TOG} alias_op_e;

  function automatic logic [REG_W-1:0] alias_apply(input logic [REG_W-1:0] cur,
                                                   input logic [REG_W-1:0] wd,
                                                   input alias_op_e op);
    case (op)
      OP_SET:  return cur | wd;
      OP_CLR:  return cur & ~wd;
      OP_TOG:  return cur ^ wd;
      default: return wd;
    endcase
  endfunction

  function automatic logic [DIVR_W-1:0] div_ratio(input logic [2:0] code);
    case (code)
      3'd0:    return DIVR_W'(1);
      3'd1:    return DIVR_W'(2);
      3'd2:    return DIVR_W'(4);
      3'd3:    return DIVR_W'(8);
      3'd4:    return DIVR_W'(16);
      3'd5:    return DIVR_W'(64);
      3'd6:    return DIVR_W'(256);
      default: return DIVR_W'(1024);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] per_top(input logic [PER_W-1:0] t);
    return t[15:0];
  endfunction
  function automatic logic [1:0] per_act_code(input logic [PER_W-1:0] t);
    return t[17:16];
  endfunction
  function automatic logic [1:0] per_idle_code(input logic [PER_W-1:0] t);
    return t[19:18];
  endfunction
  function automatic logic [2:0] per_div(input logic [PER_W-1:0] t);
    return t[22:20];
  endfunction
  function automatic logic [CNT_W-1:0] win_start(input logic [REG_W-1:0] w);
    return w[15:0];
  endfunction
  function automatic logic [CNT_W-1:0] win_end(input logic [REG_W-1:0] w);
    return w[31:16];
  endfunction
  function automatic logic drive_level(input logic [1:0] code);
    return code == 2'b11;
  endfunction
endpackage

// File: rtl/pwm_bank_regs.sv
`timescale 1ns/1ps
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [REG_W-1:0]           wdata,
  input  logic                       we,
  output logic [REG_W-1:0]           rdata,
  output logic [NCH-1:0]             run_o,
  output logic [NCH-1:0][REG_W-1:0]  win_o,
  output logic [NCH-1:0][PER_W-1:0]  tim_o
);
  localparam int NSLOT  = 2 * NCH + 1;
  localparam int SLOT_W = ADDR_W - 4;
  localparam logic [REG_W-1:0] RUN_MASK = REG_W'((64'd1 << NCH) - 64'd1);

  logic [REG_W-1:0] regs [NSLOT];
  logic [SLOT_W-1:0] slot;
  alias_op_e op;

  assign slot = addr[ADDR_W-1:4];
  assign op   = alias_op_e'(addr[3:2]);

  function automatic logic [REG_W-1:0] slot_mask(input int s);
    if (s == 0)          return RUN_MASK;
    else if (s % 2 == 0) return PER_MASK;
    else                 return '1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++) regs[s] <= '0;
    end else begin
      for (int s = 0; s < NSLOT; s++)
        if (we && slot == SLOT_W'(s))
          regs[s] <= alias_apply(regs[s], wdata, op) & slot_mask(s);
    end
  end

  always_comb begin
    rdata = '0;
    for (int s = 0; s < NSLOT; s++)
      if (slot == SLOT_W'(s)) rdata = regs[s];
  end

  assign run_o = regs[0][NCH-1:0];
  for (genvar n = 0; n < NCH; n++) begin : g_map
    assign win_o[n] = regs[2*n+1];
    assign tim_o[n] = regs[2*n+2][PER_W-1:0];
  end

  AST_SET_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && slot == '0 && op == OP_SET) |=>
      ((run_o & $past(wdata[NCH-1:0])) == $past(wdata[NCH-1:0]))); // R2
  AST_CLR_DROPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && slot == '0 && op == OP_CLR) |=>
      ((run_o & $past(wdata[NCH-1:0])) == '0)); // R2
  AST_TOG_FLIPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && slot == '0 && op == OP_TOG) |=>
      (run_o == ($past(run_o) ^ $past(wdata[NCH-1:0])))); // R2
endmodule

// File: rtl/pwm_bank_chan.sv
`timescale 1ns/1ps
module pwm_bank_chan
  import pwm_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [REG_W-1:0] win_cfg,
  input  logic [PER_W-1:0] tim_cfg,
  output logic             pwm
);
  logic [REG_W-1:0]  win_sh;
  logic [PER_W-1:0]  tim_sh;
  logic [DIVR_W-1:0] pre_cnt;
  logic [CNT_W-1:0]  cnt;
  logic              step;
  logic              wrap;
  logic              in_win;

  assign step   = run && (pre_cnt == div_ratio(per_div(tim_sh)) - DIVR_W'(1));
  assign wrap   = step && (cnt == per_top(tim_sh));
  assign in_win = (cnt >= win_start(win_sh)) && (cnt < win_end(win_sh));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      cnt     <= '0;
      win_sh  <= '0;
      tim_sh  <= '0;
    end else if (!run) begin
      pre_cnt <= '0;
      cnt     <= '0;
      win_sh  <= win_cfg;
      tim_sh  <= tim_cfg;
    end else begin
      pre_cnt <= step ? '0 : pre_cnt + DIVR_W'(1);
      if (wrap) begin
        cnt    <= '0;
        win_sh <= win_cfg;
        tim_sh <= tim_cfg;
      end else if (step) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign pwm = run ? drive_level(in_win ? per_act_code(tim_sh) : per_idle_code(tim_sh))
                   : drive_level(per_idle_code(tim_cfg));

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= per_top(tim_sh))); // R6
  AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pre_cnt < div_ratio(per_div(tim_sh)))); // R5
  AST_HOLD_BETWEEN_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !step) |=> $stable(cnt)); // R5
  AST_SHADOW_UNTIL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> ($stable(tim_sh) && $stable(win_sh))); // R10
  AST_RESTART_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt == '0 && pre_cnt == '0)); // R9
endmodule

// File: rtl/pwm_bank.sv
`timescale 1ns/1ps
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              we,
  output logic [31:0]       rdata,
  output logic [NCH-1:0]    pwm_out
);
  logic [NCH-1:0]            run;
  logic [NCH-1:0][REG_W-1:0] win;
  logic [NCH-1:0][PER_W-1:0] tim;

  pwm_bank_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .wdata (wdata),
    .we    (we),
    .rdata (rdata),
    .run_o (run),
    .win_o (win),
    .tim_o (tim)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    pwm_bank_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run[n]),
      .win_cfg (win[n]),
      .tim_cfg (tim[n]),
      .pwm     (pwm_out[n])
    );
  end
endmodule

// File: tb/pwm_bank_tb.sv
`timescale 1ns/1ps
module pwm_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic [1:0]  pwm_out;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pwm_bank #(.NCH(2), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
    .rdata(rdata), .pwm_out(pwm_out)
  );

  typedef struct packed {
    logic [2:0]  dv;
    logic [15:0] top;
    logic [15:0] st;
    logic [15:0] fin;
    logic [1:0]  act;
    logic [1:0]  ina;
    logic [1:0]  np;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 16'd9,     16'd0,     16'd5,     2'd3, 2'd2, 2'd2},
    '{3'd1, 16'd7,     16'd2,     16'd6,     2'd3, 2'd2, 2'd2},
    '{3'd2, 16'd4,     16'd0,     16'd10,    2'd3, 2'd2, 2'd1},
    '{3'd0, 16'd5,     16'd3,     16'd3,     2'd3, 2'd2, 2'd2},
    '{3'd3, 16'd3,     16'd1,     16'd3,     2'd2, 2'd3, 2'd1},
    '{3'd4, 16'd2,     16'd0,     16'd1,     2'd3, 2'd2, 2'd1},
    '{3'd5, 16'd1,     16'd0,     16'd1,     2'd3, 2'd2, 2'd1},
    '{3'd6, 16'd1,     16'd1,     16'd2,     2'd3, 2'd2, 2'd1},
    '{3'd0, 16'hFFFF,  16'hFFFE,  16'hFFFF,  2'd3, 2'd2, 2'd1},
    '{3'd0, 16'd3,     16'd0,     16'd4,     2'd1, 2'd0, 2'd1}
  };

  function automatic int ratio_of(input int code);
    return (code <= 4) ? (1 << code) : (1 << (2 * code - 4));
  endfunction

  function automatic int clocks_of(input vec_t v);
    return ratio_of(int'(v.dv)) * (int'(v.top) + 1) * int'(v.np);
  endfunction

  function automatic int expect_high(input vec_t v);
    int len = int'(v.top) + 1;
    int lim = (int'(v.fin) < len) ? int'(v.fin) : len;
    int a   = (lim > int'(v.st)) ? lim - int'(v.st) : 0;
    int hi  = ((v.act == 2'd3) ? a : 0) + ((v.ina == 2'd3) ? len - a : 0);
    return ratio_of(int'(v.dv)) * hi * int'(v.np);
  endfunction

  function automatic logic [31:0] tim_word(input vec_t v);
    return {9'd0, v.dv, v.ina, v.act, v.top};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic count_high(input int n, input int ch, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int hi;
    int hi1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    rd(8'h00, d); check("R1 reset enable reg", d, 32'h0);
    rd(8'h10, d); check("R1 reset window reg", d, 32'h0);
    rd(8'h20, d); check("R1 reset timing reg", d, 32'h0);
    check("R1 reset outputs", {30'd0, pwm_out}, 32'h0);

    // R2, R3, R4: alias arithmetic and readback
    wr(8'h20, 32'h0031_0005);
    wr(8'h24, 32'h000C_0000);
    rd(8'h20, d); check("R2 set alias", d, 32'h003D_0005);
    rd(8'h28, d); check("R3 alias read", d, 32'h003D_0005);
    wr(8'h28, 32'h0000_0005);
    rd(8'h2C, d); check("R2 clear alias", d, 32'h003D_0000);
    wr(8'h2C, 32'h0001_0001);
    rd(8'h24, d); check("R2 toggle alias", d, 32'h003C_0001);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, d); check("R4 timing upper bits", d, 32'h007F_FFFF);
    wr(8'h00, 32'h0000_00FC);
    rd(8'h00, d); check("R1 enable width", d, 32'h0);
    wr(8'h50, 32'h1234_5678);
    rd(8'h50, d); check("R3 unmapped read", d, 32'h0);
    wr(8'h34, 32'hA5A5_0000);
    rd(8'h30, d); check("R4 ch1 window map", d, 32'hA5A5_0000);
    wr(8'h30, 32'h0);
    wr(8'h20, 32'h0);

    // R5..R8: table of vectors on channel 0
    for (int k = 0; k < NV; k++) begin
      wr(8'h08, 32'h1);
      wr(8'h10, {VECS[k].fin, VECS[k].st});
      wr(8'h20, tim_word(VECS[k]));
      wr(8'h04, 32'h1);
      count_high(clocks_of(VECS[k]), 0, hi);
      check($sformatf("R5 R6 R7 R8 vector %0d", k), hi, expect_high(VECS[k]));
    end

    // R9: disable drives live inactive code, restart from count 0
    wr(8'h08, 32'h1);
    wr(8'h10, 32'h0003_0000);
    wr(8'h20, {9'd0, 3'd0, 2'd3, 2'd2, 16'd9});
    @(negedge clk); check("R9 idle high while disabled", {31'd0, pwm_out[0]}, 32'h1);
    wr(8'h20, {9'd0, 3'd0, 2'd2, 2'd3, 16'd9});
    wr(8'h04, 32'h1);
    count_high(5, 0, hi);
    wr(8'h08, 32'h1);
    @(negedge clk); check("R9 low after disable", {31'd0, pwm_out[0]}, 32'h0);
    wr(8'h04, 32'h1);
    count_high(10, 0, hi);
    check("R9 restart full window", hi, 3);

    // R10: window change mid-period waits for wrap
    wr(8'h08, 32'h1);
    wr(8'h10, 32'h0005_0000);
    wr(8'h04, 32'h1);
    wr(8'h10, 32'h0008_0000);
    count_high(9, 0, hi);
    check("R10 old window holds", hi, 4);
    count_high(10, 0, hi);
    check("R10 new window after wrap", hi, 8);

    // R11: channel 1 alone with the slowest ratio
    wr(8'h08, 32'h3);
    wr(8'h20, {9'd0, 3'd0, 2'd2, 2'd3, 16'd1});
    wr(8'h30, 32'h0001_0000);
    wr(8'h40, {9'd0, 3'd7, 2'd2, 2'd3, 16'd1});
    wr(8'h04, 32'h2);
    hi = 0; hi1 = 0;
    for (int i = 0; i < 2048; i++) begin
      @(negedge clk);
      if (pwm_out[0]) hi++;
      if (pwm_out[1]) hi1++;
    end
    check("R11 ch1 ratio 1024", hi1, 1024);
    check("R11 ch0 untouched", hi, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule